// File: doc/BRIEF.md
# Byte-Wide Configuration Register Loader

This block fills a bank of wide configuration registers from a narrow 8-bit bus. A host drives the bus, a cycle-type select (address or data), a byte-half select, and a load strobe. The strobe has no timing relation to the system clock. The cycle-type and byte-half selects are captured when the strobe falls. The bus value is taken when the strobe rises. An address cycle points the loader at one register. A data cycle then writes either the low byte or the upper nibble of that register. Each 12-bit register is therefore built from two bus transfers.

An address cycle that has the byte-half select set also turns on auto-load. After that, every upper-nibble write moves the pointer to the next register, so a host can fill the whole bank as a stream of low/high pairs. Each data cycle is first held in a staging register in the strobe domain. A toggle then carries it into the clock domain through a two-flop synchronizer, and the bank is updated there from a one-cycle write pulse. The bank is presented as one flat vector to the timing logic that uses it.

Clear is asynchronous and loads a non-zero default into every register. The status register at index 0 defaults either to all zeros or to a value with only its clock-enable bit set, depending on a parameter. The index one past the last register has no storage, and writes to it are dropped.

Top module: `byte_reg_loader`

## Requirements
- R1: While `rst_n` is low, and afterwards until a write arrives, register k (k = 1..14) holds bits [k*12 +: 12] of `DEF_BANK`. Register 0 holds 0x400 when `CLK_ON_START` = 1 and 0x000 otherwise. The clear also sets the address pointer to 0 and turns auto-load off.
- R2: In an address cycle (`sel_data` = 0 when the strobe falls), `bus_in[3:0]` is loaded into the address pointer on the rising strobe edge, and no register in the bank changes.
- R3: In a low data cycle (`sel_data` = 1, `sel_hi` = 0), bits [7:0] of the addressed register become `bus_in`, and bits [11:8] keep their value.
- R4: In a high data cycle (`sel_data` = 1, `sel_hi` = 1), bits [11:8] of the addressed register become `bus_in[3:0]`. Bits [7:0] keep their value, and `bus_in[7:4]` is ignored.
- R5: `sel_data` and `sel_hi` count only at the falling strobe edge. Changing them before the rising edge has no effect on that cycle.
- R6: An address cycle with `sel_hi` = 1 turns auto-load on. While auto-load is on, each high data cycle moves the pointer up by one after its write. Low data cycles leave the pointer where it is.
- R7: An address cycle with `sel_hi` = 0 turns auto-load off, so later high data cycles leave the pointer unchanged.
- R8: A data cycle aimed at address 15 changes no register. Under auto-load, a high write at 14 moves the pointer to 15.
- R9: A data write shows on `cfg_flat` at the third rising `clk` edge after the strobe rises, and not before. Each data write changes only the one addressed register. Strobe edges must be at least four `clk` periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| ld_stb | input | 1 | Load strobe: selects captured on fall, bus captured on rise |
| sel_data | input | 1 | Cycle type: 0 address, 1 data |
| sel_hi | input | 1 | Byte half: 0 low byte, 1 upper nibble (auto-load in address cycle) |
| bus_in | input | 8 | Host data bus |
| cfg_flat | output | 180 | Register bank, register k at bits [k*12 +: 12] |

## Verification
The bench builds the loader with `CLK_ON_START` = 1. It also gives `DEF_BANK` a different, non-zero default in every register, computed as 0xA00 plus 0x11 times the index. With these values, a register that has been written can never be mistaken for one that has not, and the clear is seen to load the clock-enabled status value. Because every default has 0xA in its upper nibble, each low-byte write can be checked against a known upper half. The wrap of the auto-load pointer from 14 onto the unstored index 15 is also exercised.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic {
    CYC_ADDR = 1'b0,
    CYC_DATA = 1'b1
  } cyc_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/lr_strobe_capture.sv
module lr_strobe_capture
  import lr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int AW    = 4
) (
  input  logic             ld_stb,
  input  logic             rst_n,
  input  logic             sel_data,
  input  logic             sel_hi,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] stg_data,
  output logic [AW-1:0]    stg_addr,
  output logic             stg_hi,
  output logic             wr_tog
);
  cyc_e  ph_cyc_q;
  half_e ph_half_q;

  logic [AW-1:0]    addr_q, addr_d;
  logic             auto_q, auto_d;
  logic [BUS_W-1:0] data_q, data_d;
  logic [AW-1:0]    saddr_q, saddr_d;
  logic             shi_q, shi_d;
  logic             tog_q, tog_d;

  // Selects are taken on the falling strobe edge.
  always_ff @(negedge ld_stb or negedge rst_n) begin
    if (!rst_n) begin
      ph_cyc_q  <= CYC_ADDR;
      ph_half_q <= HALF_LO;
    end else begin
      ph_cyc_q  <= cyc_e'(sel_data);
      ph_half_q <= half_e'(sel_hi);
    end
  end

  always_comb begin
    addr_d  = addr_q;
    auto_d  = auto_q;
    data_d  = data_q;
    saddr_d = saddr_q;
    shi_d   = shi_q;
    tog_d   = tog_q;
    if (ph_cyc_q == CYC_ADDR) begin
      addr_d = bus_in[AW-1:0];
      auto_d = (ph_half_q == HALF_HI);
    end else begin
      data_d  = bus_in;
      saddr_d = addr_q;
      shi_d   = (ph_half_q == HALF_HI);
      tog_d   = ~tog_q;
      if (auto_q && (ph_half_q == HALF_HI)) begin
        addr_d = addr_q + AW'(1);
      end
    end
  end

  // Bus is taken on the rising strobe edge.
  always_ff @(posedge ld_stb or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      auto_q  <= 1'b0;
      data_q  <= '0;
      saddr_q <= '0;
      shi_q   <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      auto_q  <= auto_d;
      data_q  <= data_d;
      saddr_q <= saddr_d;
      shi_q   <= shi_d;
      tog_q   <= tog_d;
    end
  end

  assign stg_data = data_q;
  assign stg_addr = saddr_q;
  assign stg_hi   = shi_q;
  assign wr_tog   = tog_q;
endmodule

// File: rtl/lr_pulse_sync.sv
module lr_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;
  logic [1:0]        rsync_q;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = tog_in;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], tog_in};
    end
  endgenerate
  assign prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign pulse = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lr_reg_bank.sv
module lr_reg_bank #(
  parameter int NUM_REGS = 15,
  parameter int REG_W    = 12,
  parameter int BUS_W    = 8,
  parameter int AW       = 4,
  parameter logic [NUM_REGS*REG_W-1:0] BANK_DEF = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_pulse,
  input  logic [AW-1:0]             stg_addr,
  input  logic                      stg_hi,
  input  logic [BUS_W-1:0]          stg_data,
  output logic [NUM_REGS*REG_W-1:0] cfg_flat
);
  localparam int LO_W = BUS_W;
  localparam int HI_W = REG_W - BUS_W;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [REG_W-1:0] DEF = BANK_DEF[g*REG_W +: REG_W];
      logic [REG_W-1:0] val_q, val_d;
      logic             hit;

      assign hit = wr_pulse && (stg_addr == AW'(g));

      always_comb begin
        val_d = val_q;
        if (hit) begin
          if (stg_hi) val_d[REG_W-1:LO_W] = stg_data[HI_W-1:0];
          else        val_d[LO_W-1:0]     = stg_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= DEF;
        else if (hit) val_q <= val_d;
      end

      assign cfg_flat[g*REG_W +: REG_W] = val_q;
    end
  endgenerate
endmodule

// File: rtl/byte_reg_loader.sv
module byte_reg_loader #(
  parameter int NUM_REGS      = 15,
  parameter int REG_W         = 12,
  parameter int BUS_W         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int STATUS_EN_BIT = 10,
  parameter bit CLK_ON_START  = 1'b0,
  parameter logic [NUM_REGS*REG_W-1:0] DEF_BANK = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_stb,
  input  logic                      sel_data,
  input  logic                      sel_hi,
  input  logic [BUS_W-1:0]          bus_in,
  output logic [NUM_REGS*REG_W-1:0] cfg_flat
);
  localparam int AW = $clog2(NUM_REGS);
  localparam logic [REG_W-1:0] STATUS_DEF =
    CLK_ON_START ? (REG_W'(1) << STATUS_EN_BIT) : '0;
  localparam logic [NUM_REGS*REG_W-1:0] BANK_DEF =
    {DEF_BANK[NUM_REGS*REG_W-1:REG_W], STATUS_DEF};

  logic [BUS_W-1:0] stg_data;
  logic [AW-1:0]    stg_addr;
  logic             stg_hi;
  logic             wr_tog;
  logic             wr_pulse;
  logic             rst_sync_n;

  lr_strobe_capture #(.BUS_W(BUS_W), .AW(AW)) u_cap (
    .ld_stb   (ld_stb),
    .rst_n    (rst_n),
    .sel_data (sel_data),
    .sel_hi   (sel_hi),
    .bus_in   (bus_in),
    .stg_data (stg_data),
    .stg_addr (stg_addr),
    .stg_hi   (stg_hi),
    .wr_tog   (wr_tog)
  );

  lr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tog_in     (wr_tog),
    .pulse      (wr_pulse),
    .rst_sync_n (rst_sync_n)
  );

  lr_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .BUS_W    (BUS_W),
    .AW       (AW),
    .BANK_DEF (BANK_DEF)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_pulse (wr_pulse),
    .stg_addr (stg_addr),
    .stg_hi   (stg_hi),
    .stg_data (stg_data),
    .cfg_flat (cfg_flat)
  );
endmodule

// File: rtl/lr_chk.sv
module lr_chk #(
  parameter int NUM_REGS = 15,
  parameter int REG_W    = 12,
  parameter int BUS_W    = 8,
  parameter int AW       = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_pulse,
  input logic [AW-1:0]             stg_addr,
  input logic                      stg_hi,
  input logic [BUS_W-1:0]          stg_data,
  input logic [NUM_REGS*REG_W-1:0] cfg_flat
);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(cfg_flat));

  // R8
  unstored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && (int'(stg_addr) >= NUM_REGS)) |=> $stable(cfg_flat));

  // R3
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !stg_hi && (int'(stg_addr) < NUM_REGS)) |=>
      (cfg_flat[int'($past(stg_addr))*REG_W +: BUS_W] == $past(stg_data)));
endmodule

bind byte_reg_loader lr_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .BUS_W    (BUS_W),
  .AW       (AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_pulse (wr_pulse),
  .stg_addr (stg_addr),
  .stg_hi   (stg_hi),
  .stg_data (stg_data),
  .cfg_flat (cfg_flat)
);

// File: tb/byte_reg_loader_tb.sv
module byte_reg_loader_tb;
  localparam int NR = 15;
  localparam int RW = 12;
  localparam int NV = 18;

  function automatic logic [NR*RW-1:0] mk_def();
    logic [NR*RW-1:0] r;
    r = '0;
    for (int k = 0; k < NR; k++) r[k*RW +: RW] = 12'hA00 + RW'(k * 17);
    return r;
  endfunction
  localparam logic [NR*RW-1:0] DEFS = mk_def();

  // {addr/data, hi, bus, check index, expected, requirement}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h03, 4'd3,  12'hA33, 6'd2},  // R2 pointer 3, bank untouched
    {1'b1, 1'b0, 8'h5C, 4'd3,  12'hA5C, 6'd3},  // R3
    {1'b1, 1'b1, 8'hF7, 4'd3,  12'h75C, 6'd4},  // R4 upper bus bits dropped
    {1'b1, 1'b0, 8'h12, 4'd3,  12'h712, 6'd3},  // R3 keeps nibble
    {1'b0, 1'b0, 8'h0F, 4'd14, 12'hAEE, 6'd8},  // R8 pointer 15
    {1'b1, 1'b0, 8'h99, 4'd0,  12'h400, 6'd8},  // R8 ignored
    {1'b1, 1'b1, 8'h03, 4'd14, 12'hAEE, 6'd8},  // R8 ignored
    {1'b0, 1'b1, 8'h05, 4'd5,  12'hA55, 6'd6},  // R6 auto on
    {1'b1, 1'b0, 8'h01, 4'd5,  12'hA01, 6'd6},  // R6
    {1'b1, 1'b1, 8'h02, 4'd5,  12'h201, 6'd6},  // R6 pointer to 6
    {1'b1, 1'b0, 8'h03, 4'd6,  12'hA03, 6'd6},  // R6 advanced
    {1'b1, 1'b1, 8'h04, 4'd6,  12'h403, 6'd6},  // R6 pointer to 7
    {1'b1, 1'b0, 8'h0A, 4'd7,  12'hA0A, 6'd6},  // R6
    {1'b1, 1'b0, 8'h0B, 4'd7,  12'hA0B, 6'd6},  // R6 low does not advance
    {1'b0, 1'b0, 8'h08, 4'd8,  12'hA88, 6'd7},  // R7 auto off
    {1'b1, 1'b1, 8'h01, 4'd8,  12'h188, 6'd7},  // R7
    {1'b1, 1'b0, 8'h02, 4'd8,  12'h102, 6'd7},  // R7 no advance
    {1'b1, 1'b0, 8'h06, 4'd9,  12'hA99, 6'd7}   // R7 neighbour untouched
  };

  logic             clk;
  logic             rst_n;
  logic             ld_stb;
  logic             sel_data;
  logic             sel_hi;
  logic [7:0]       bus_in;
  logic [NR*RW-1:0] cfg_flat;

  int n_chk;
  int n_bad;

  byte_reg_loader #(
    .CLK_ON_START (1'b1),
    .DEF_BANK     (DEFS)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_stb   (ld_stb),
    .sel_data (sel_data),
    .sel_hi   (sel_hi),
    .bus_in   (bus_in),
    .cfg_flat (cfg_flat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int idx, input logic [RW-1:0] exp, input string req);
    logic [RW-1:0] act;
    act = cfg_flat[idx*RW +: RW];
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s reg%0d actual %03h expected %03h", req, idx, act, exp);
    end
  endtask

  task automatic strobe(input logic ad, input logic hi, input logic [7:0] d);
    @(negedge clk);
    sel_data = ad;
    sel_hi   = hi;
    bus_in   = d;
    #2 ld_stb = 1'b0;
    #5 ld_stb = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_chk    = 0;
    n_bad    = 0;
    rst_n    = 1'b0;
    ld_stb   = 1'b1;
    sel_data = 1'b0;
    sel_hi   = 1'b0;
    bus_in   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 defaults after clear, status clock-enable bit set
    for (int k = 0; k < NR; k++)
      check(k, (k == 0) ? 12'h400 : DEFS[k*RW +: RW], "R1");

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][31], VEC[i][30], VEC[i][29:22]);
      check(int'(VEC[i][21:18]), VEC[i][17:6], $sformatf("R%0d", VEC[i][5:0]));
    end

    // R4 status register writable through both halves
    strobe(1'b0, 1'b0, 8'h00);
    strobe(1'b1, 1'b0, 8'h00);
    strobe(1'b1, 1'b1, 8'h00);
    check(0, 12'h000, "R4");

    // R8 auto-load runs from 14 onto the unstored index
    strobe(1'b0, 1'b1, 8'h0E);
    strobe(1'b1, 1'b0, 8'h11);
    strobe(1'b1, 1'b1, 8'h01);
    check(14, 12'h111, "R8");
    strobe(1'b1, 1'b0, 8'h22);
    check(14, 12'h111, "R8");
    check(0, 12'h000, "R8");

    // R5 selects change between the strobe edges
    strobe(1'b0, 1'b0, 8'h02);
    @(negedge clk);
    sel_data = 1'b1;
    sel_hi   = 1'b0;
    bus_in   = 8'h77;
    #2 ld_stb = 1'b0;
    #2 sel_data = 1'b0;
    sel_hi = 1'b1;
    #2 ld_stb = 1'b1;
    repeat (6) @(negedge clk);
    check(2, 12'hA77, "R5");
    strobe(1'b1, 1'b1, 8'h03);
    check(2, 12'h377, "R5");
    check(7, 12'hA0B, "R5");

    // R9 update lands on the third clock edge after the strobe rises
    @(negedge clk);
    sel_data = 1'b1;
    sel_hi   = 1'b0;
    bus_in   = 8'hC4;
    #1 ld_stb = 1'b0;
    #2 ld_stb = 1'b1;
    #1 check(2, 12'h377, "R9");
    @(negedge clk);
    check(2, 12'h377, "R9");
    @(negedge clk);
    check(2, 12'h377, "R9");
    @(negedge clk);
    check(2, 12'h3C4, "R9");
    check(3, 12'h712, "R9");
    repeat (4) @(negedge clk);

    // R1 clear restores all defaults, pointer 0, auto off
    do_clear();
    for (int k = 0; k < NR; k++)
      check(k, (k == 0) ? 12'h400 : DEFS[k*RW +: RW], "R1");
    strobe(1'b1, 1'b0, 8'h5A);
    strobe(1'b1, 1'b1, 8'h06);
    strobe(1'b1, 1'b0, 8'h6B);
    check(0, 12'h66B, "R1");
    check(1, 12'hA11, "R1");

    finish_run();
  end
endmodule